// File: doc/BRIEF.md
# Bus Mode Detect and Reconfiguration Request

This block watches the mode-initialization lines that a host drives while the bus reset is held low. It decides from them which signalling mode the bus will use after reset: conventional 33 MHz, the split-transaction extension at 66 MHz, or the same extension at 133 MHz. It then checks that mode against the set of modes that the currently loaded logic image can serve.

While bus reset is low, the capture stage follows the lines on every clock edge, so the reported mode and the request flag can move during that window. On release they freeze. If the frozen mode cannot be served, the block raises a reload request so that an external controller can load a different image. It also keeps a qualified reset asserted toward the core and user logic, so that nothing behind it takes part in bus traffic.

The detector itself sits outside that qualified reset. A later bus reset into a mode that the image supports therefore clears the request and lets the core run. A build-time selector names the supported set, and an optional forcing input can replace that selector.

Top module: `bus_mode_detect`

## Requirements
- R1: The three mode lines decode as follows:
  - 000 gives mode 0 (conventional).
  - 001 and 010 give mode 1 (66 MHz extension).
  - 011 gives mode 2 (133 MHz extension).
  - Any pattern with bit 2 set gives mode 3 (unsupported).
- R2: The supported-set selector chooses one of four sets:
  - 0 means modes 0 and 1.
  - 1 means mode 0 only.
  - 2 means mode 1 only.
  - 3 means mode 2 only.
- R3: When force_en_i is high, force_sel_i replaces cap_sel_i as the supported-set selector. The encoding is the same as in R2.
- R4: After release, reload_req_o is 1 exactly when the frozen mode is outside the selected set. Mode 3 is never in any set.
- R5: On each clock edge that samples bus_rst_n low, mode_o and reload_req_o load from the live lines and selector, and core_rst_n_o is driven low. The outputs are therefore one cycle behind the lines.
- R6: From the first edge that samples bus_rst_n high, core_rst_n_o equals the inverse of reload_req_o.
- R7: While bus_rst_n stays high, changes on the mode lines, cap_sel_i, force_en_i or force_sel_i leave mode_o and reload_req_o unchanged.
- R8: A later bus reset reopens capture. A second reset into a supported mode clears reload_req_o and raises core_rst_n_o after release.
- R9: The frozen mode is the one decoded at the last edge that sampled bus_rst_n low. Earlier toggling of the lines has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| bus_rst_n | input | 1 | Bus reset, active low; the capture window |
| mode_pat_i | input | 3 | Mode-initialization lines driven by the host during reset |
| cap_sel_i | input | 2 | Build-time supported-set selector |
| force_en_i | input | 1 | Enables the forcing selector |
| force_sel_i | input | 2 | Forcing supported-set selector |
| mode_o | output | 2 | Frozen bus mode code |
| reload_req_o | output | 1 | Request to load a different image |
| core_rst_n_o | output | 1 | Qualified reset to core and user logic, active low |

## Verification
The state of this block is only the frozen mode, the request and the qualified reset, so any internal fault shows directly on the ports. The fault becomes visible one clock edge after the reset edge that sets up the wrong value.

A capture that freezes late, or that keeps loading after release, shows as mode_o moving while bus_rst_n is high. A wrong supported-set mask, or a wrong choice between the forcing and build-time selectors, shows as a wrong reload_req_o on the first cycle after release. That fault also shows as a qualified reset that stays low, or goes high, when it should not.

// File: rtl/bmd_pkg.sv
package bmd_pkg;
    localparam int PAT_W    = 3;
    localparam int SEL_W    = 2;
    localparam int MODE_NUM = 4;

    typedef enum logic [1:0] {
        MODE_CONV = 2'd0,
        MODE_X66  = 2'd1,
        MODE_X133 = 2'd2,
        MODE_BAD  = 2'd3
    } bus_mode_e;

    typedef struct packed {
        bus_mode_e mode;
        logic      req;
        logic      core_rst_n;
    } bmd_state_t;

    // Bit m set: mode code m is served by supported set s.
    function automatic logic [MODE_NUM-1:0] set_mask(input logic [SEL_W-1:0] s);
        logic [MODE_NUM-1:0] m;
        case (s)
            2'd0:    m = 4'b0011;
            2'd1:    m = 4'b0001;
            2'd2:    m = 4'b0010;
            default: m = 4'b0100;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/bmd_decode.sv
module bmd_decode
    import bmd_pkg::*;
#(
    parameter int W = PAT_W
) (
    input  logic [W-1:0] pat_i,
    output bus_mode_e    mode_o
);
    logic high_set;

    always_comb begin
        high_set = 1'b0;
        for (int i = 2; i < W; i++) begin
            high_set = high_set | pat_i[i];
        end
    end

    always_comb begin
        if (high_set) begin
            mode_o = MODE_BAD;
        end else begin
            case (pat_i[1:0])
                2'b00:   mode_o = MODE_CONV;
                2'b01:   mode_o = MODE_X66;
                2'b10:   mode_o = MODE_X66;
                default: mode_o = MODE_X133;
            endcase
        end
    end
endmodule

// File: rtl/bmd_support.sv
module bmd_support
    import bmd_pkg::*;
#(
    parameter int SW = SEL_W,
    parameter int MN = MODE_NUM
) (
    input  logic [SW-1:0] cap_sel_i,
    input  logic          force_en_i,
    input  logic [SW-1:0] force_sel_i,
    input  bus_mode_e     mode_i,
    output logic          ok_o
);
    logic [SW-1:0] eff_sel;
    logic [MN-1:0] mask;
    logic [MN-1:0] hit;

    assign eff_sel = force_en_i ? force_sel_i : cap_sel_i;
    assign mask    = set_mask(eff_sel);

    for (genvar m = 0; m < MN; m++) begin : g_hit
        assign hit[m] = mask[m] & (mode_i == bus_mode_e'(m));
    end

    assign ok_o = |hit;
endmodule

// File: rtl/bus_mode_detect.sv
module bus_mode_detect
    import bmd_pkg::*;
(
    input  logic             clk,
    input  logic             bus_rst_n,
    input  logic [PAT_W-1:0] mode_pat_i,
    input  logic [SEL_W-1:0] cap_sel_i,
    input  logic             force_en_i,
    input  logic [SEL_W-1:0] force_sel_i,
    output logic [1:0]       mode_o,
    output logic             reload_req_o,
    output logic             core_rst_n_o
);
    bus_mode_e  live_mode;
    logic       live_ok;
    bmd_state_t st_d, st_q;

    bmd_decode #(.W(PAT_W)) u_decode (
        .pat_i  (mode_pat_i),
        .mode_o (live_mode)
    );

    bmd_support #(.SW(SEL_W), .MN(MODE_NUM)) u_support (
        .cap_sel_i   (cap_sel_i),
        .force_en_i  (force_en_i),
        .force_sel_i (force_sel_i),
        .mode_i      (live_mode),
        .ok_o        (live_ok)
    );

    // Capture follows the lines while reset is low, then holds.
    always_comb begin
        st_d = st_q;
        if (!bus_rst_n) begin
            st_d.mode       = live_mode;
            st_d.req        = ~live_ok;
            st_d.core_rst_n = 1'b0;
        end else begin
            st_d.core_rst_n = ~st_q.req;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign mode_o       = st_q.mode;
    assign reload_req_o = st_q.req;
    assign core_rst_n_o = st_q.core_rst_n;

    // R7
    mode_frozen_chk: assert property (@(posedge clk) disable iff (!bus_rst_n)
        $past(bus_rst_n) |-> $stable(mode_o));

    // R7
    req_frozen_chk: assert property (@(posedge clk) disable iff (!bus_rst_n)
        $past(bus_rst_n) |-> $stable(reload_req_o));

    // R5
    core_held_chk: assert property (@(posedge clk) disable iff (!bus_rst_n)
        !$past(bus_rst_n) |-> !core_rst_n_o);

    // R6
    core_vs_req_chk: assert property (@(posedge clk) disable iff (!bus_rst_n)
        $past(bus_rst_n) |-> (core_rst_n_o != reload_req_o));

    // R4
    bad_mode_req_chk: assert property (@(posedge clk) disable iff (!bus_rst_n)
        $past(bus_rst_n) && (mode_o == 2'd3) |-> reload_req_o);
endmodule

// File: tb/bus_mode_detect_bench.sv
module bus_mode_detect_bench;
    logic       clk = 1'b0;
    logic       bus_rst_n;
    logic [2:0] mode_pat_i;
    logic [1:0] cap_sel_i;
    logic       force_en_i;
    logic [1:0] force_sel_i;
    logic [1:0] mode_o;
    logic       reload_req_o;
    logic       core_rst_n_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    bus_mode_detect u_bus_mode_detect (
        .clk          (clk),
        .bus_rst_n    (bus_rst_n),
        .mode_pat_i   (mode_pat_i),
        .cap_sel_i    (cap_sel_i),
        .force_en_i   (force_en_i),
        .force_sel_i  (force_sel_i),
        .mode_o       (mode_o),
        .reload_req_o (reload_req_o),
        .core_rst_n_o (core_rst_n_o)
    );

    // cap(2) force_en(1) force_sel(2) pattern(3) exp_mode(2) exp_req(1)
    localparam int NVEC = 12;
    localparam logic [10:0] VEC [NVEC] = '{
        11'b00_0_00_000_00_0,
        11'b00_0_00_001_01_0,
        11'b00_0_00_011_10_1,
        11'b01_0_00_001_01_1,
        11'b01_0_00_000_00_0,
        11'b10_0_00_010_01_0,
        11'b11_0_00_011_10_0,
        11'b11_0_00_000_00_1,
        11'b11_1_01_000_00_0,
        11'b01_1_11_011_10_0,
        11'b00_0_00_100_11_1,
        11'b11_0_00_111_11_1
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Hold reset with a fixed pattern, release, and wait two edges.
    task automatic bus_reset(input logic [2:0] pat);
        @(negedge clk);
        bus_rst_n  = 1'b0;
        mode_pat_i = pat;
        repeat (4) @(negedge clk);
        bus_rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        bus_rst_n   = 1'b0;
        mode_pat_i  = 3'b000;
        cap_sel_i   = 2'd0;
        force_en_i  = 1'b0;
        force_sel_i = 2'd0;

        // R5: reset state, and the mode follows the lines one edge later.
        repeat (3) @(negedge clk);
        chk("R5 core_rst_n in reset", core_rst_n_o, 0);
        chk("R5 mode in reset", mode_o, 0);
        mode_pat_i = 3'b001;
        @(negedge clk);
        chk("R5 mode follows 001", mode_o, 1);
        mode_pat_i = 3'b011;
        @(negedge clk);
        chk("R5 mode follows 011", mode_o, 2);
        chk("R5 core_rst_n still low", core_rst_n_o, 0);

        // Table walk covering R1, R2, R3, R4 and R6.
        for (int i = 0; i < NVEC; i++) begin
            cap_sel_i   = VEC[i][10:9];
            force_en_i  = VEC[i][8];
            force_sel_i = VEC[i][7:6];
            bus_reset(VEC[i][5:3]);
            chk("R1 mode", mode_o, VEC[i][2:1]);
            chk(VEC[i][8] ? "R3 req" : "R2 R4 req", reload_req_o, VEC[i][0]);
            chk("R6 core_rst_n", core_rst_n_o, !VEC[i][0]);
        end

        // R8: a conventional reset against the 133-only set, then a 133 reset.
        cap_sel_i  = 2'd3;
        force_en_i = 1'b0;
        bus_reset(3'b000);
        chk("R8 req after conventional", reload_req_o, 1);
        chk("R8 core held", core_rst_n_o, 0);
        bus_reset(3'b011);
        chk("R8 req cleared", reload_req_o, 0);
        chk("R8 core released", core_rst_n_o, 1);
        chk("R8 mode 133", mode_o, 2);

        // R9: toggling during reset; only the last sampled value counts.
        cap_sel_i = 2'd0;
        @(negedge clk);
        bus_rst_n  = 1'b0;
        mode_pat_i = 3'b100;
        @(negedge clk);
        mode_pat_i = 3'b011;
        @(negedge clk);
        mode_pat_i = 3'b000;
        @(negedge clk);
        mode_pat_i = 3'b001;
        @(negedge clk);
        bus_rst_n  = 1'b1;
        mode_pat_i = 3'b111;
        repeat (2) @(negedge clk);
        chk("R9 frozen mode", mode_o, 1);
        chk("R9 frozen req", reload_req_o, 0);

        // R7: line and selector changes after release are ignored.
        mode_pat_i  = 3'b011;
        cap_sel_i   = 2'd1;
        force_en_i  = 1'b1;
        force_sel_i = 2'd3;
        repeat (3) @(negedge clk);
        chk("R7 mode held", mode_o, 1);
        chk("R7 req held", reload_req_o, 0);
        chk("R7 core held high", core_rst_n_o, 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule